// File: doc/BRIEF.md
# Multi-Level Interrupt Mask Controller

This block gathers device interrupt request lines into four priority levels, numbered 3 to 6, with four devices at each level. Each level has a status register and an enable register on a small synchronous register bus. The block drives one request output per level. An output is high when at least one enabled device at that level is requesting.

Software never overwrites an enable register. Bit 7 of the write data picks the operation. When bit 7 is 1, every device with a 1 in the low nibble is enabled. When bit 7 is 0, every such device is disabled. Devices with a 0 in the nibble keep their state. One write can therefore change several enables without a read-modify-write.

The request inputs are level-sensitive and asynchronous to the bus clock. They pass through a two-flop synchronizer before they reach the status registers and the request logic. At level 4 the bits carry, from bit 0 upward: a signal-processor device, serial channel A, serial channel B and network DMA completion.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset every enable bit is 0, `irq_out` is 0 and `rd_data` is 0x00.
- R2: For level L (3 to 6), the status register is at 0x100 + 0x10·L and the enable register is at 0x104 + 0x10·L. Device d of level L enters on `dev_req[4·(L-3)+d]`. The level drives `irq_out[L-3]`.
- R3: A status read returns the synchronized raw requests of its level, one bit per device, unmasked by the enables. An input change is visible to a read strobe issued at least two clock edges after the change.
- R4: An enable read returns the current enable mask of its level.
- R5: A write to an enable register with bit 7 = 1 sets each enable whose bit in `wr_data[3:0]` is 1. Examples: 0x81 enables device 0 only, and 0x86 enables devices 1 and 2. Setting an enable that is already set leaves it set.
- R6: A write with bit 7 = 0 clears each enable whose bit in `wr_data[3:0]` is 1. Example: 0x02 disables device 1 only. Clearing an enable that is already clear leaves it clear. Under either mode, enables whose nibble bit is 0 do not change, and bits 6:4 are ignored.
- R7: `irq_out[i]` is the registered OR of (status AND enable) over level i. It changes on the clock edge after an enable write takes effect, and three edges after a request input changes.
- R8: Bits 7:4 of every read are 0.
- R9: A read of any address other than the eight defined registers returns 0x00. A write to such an address, or to a status register, changes no enable.
- R10: `rd_data` is registered. It takes its new value on the edge that samples `rd_en` and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Register byte address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_data | input | 8 | Write data; bit 7 selects set or clear, bits 3:0 select devices |
| rd_data | output | 8 | Registered read data |
| dev_req | input | 16 | Raw device requests, four per level, level 3 in the low nibble |
| irq_out | output | 4 | Per-level request, bit 0 for level 3 |

## Verification
Each result has a fixed latency after its stimulus:
- Read data appears one edge after the read strobe.
- An enable write takes effect on the edge that samples it, and `irq_out` follows on the next edge.
- A request input reaches the status registers after two edges and reaches `irq_out` after three.

The bench drives inputs on falling edges and samples on the falling edge after the edge where each result is due. It also checks the cycle just before some results are due, so a result that arrives early or late fails.

// File: rtl/irq_pkg.sv
package irq_pkg;
    parameter int LVL_FIRST   = 3;
    parameter int NUM_LVL     = 4;
    parameter int DEV_PER_LVL = 4;
    parameter int ADDR_W      = 12;
    parameter int DATA_W      = 8;
    parameter int STAT_OFS    = 'h100;
    parameter int EN_OFS      = 'h104;
    parameter int LVL_STRIDE  = 'h10;

    localparam int NUM_DEV = NUM_LVL * DEV_PER_LVL;
    localparam int MODE_BIT = DATA_W - 1;

    typedef enum logic [1:0] {
        FLD_NONE,
        FLD_STAT,
        FLD_EN
    } field_e;

    function automatic logic [ADDR_W-1:0] stat_addr(input int idx);
        return ADDR_W'(STAT_OFS + LVL_STRIDE * (idx + LVL_FIRST));
    endfunction

    function automatic logic [ADDR_W-1:0] en_addr(input int idx);
        return ADDR_W'(EN_OFS + LVL_STRIDE * (idx + LVL_FIRST));
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/irq_level.sv
module irq_level #(
    parameter int NDEV = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NDEV-1:0] stat,
    input  logic            we,
    input  logic            set_mode,
    input  logic [NDEV-1:0] mask,
    output logic [NDEV-1:0] en_q,
    output logic            irq_q
);
    logic [NDEV-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (we) begin
            unique case (set_mode)
                1'b1: en_d = en_q | mask;
                1'b0: en_d = en_q & ~mask;
                default: en_d = en_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            en_q  <= en_d;
            irq_q <= |(stat & en_q);
        end
    end
endmodule

// File: rtl/irq_regbus.sv
module irq_regbus
    import irq_pkg::*;
#(
    parameter int NL = NUM_LVL,
    parameter int ND = DEV_PER_LVL,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [DW-1:0]    wr_data,
    input  logic [NL*ND-1:0] stat_flat,
    input  logic [NL*ND-1:0] en_flat,
    output logic [NL-1:0]    en_we,
    output logic             set_mode,
    output logic [ND-1:0]    mask,
    output logic [DW-1:0]    rd_data
);
    field_e        fld;
    logic [ND-1:0] sel_bits;
    logic [NL-1:0] en_hit;
    logic [DW-1:0] rd_mux;
    logic          unused_wbits;

    assign set_mode     = wr_data[DW-1];
    assign mask         = wr_data[ND-1:0];
    assign unused_wbits = ^wr_data[DW-2:ND];

    always_comb begin
        fld      = FLD_NONE;
        sel_bits = '0;
        en_hit   = '0;
        for (int i = 0; i < NL; i++) begin
            if (addr == stat_addr(i)) begin
                fld      = FLD_STAT;
                sel_bits = stat_flat[i*ND +: ND];
            end
            if (addr == en_addr(i)) begin
                fld       = FLD_EN;
                sel_bits  = en_flat[i*ND +: ND];
                en_hit[i] = 1'b1;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (fld)
            FLD_STAT, FLD_EN: rd_mux = {{(DW-ND){1'b0}}, sel_bits};
            default:          rd_mux = '0;
        endcase
    end

    assign en_we = wr_en ? en_hit : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     rd_data,
    input  logic [NUM_DEV-1:0]    dev_req,
    output logic [NUM_LVL-1:0]    irq_out
);
    logic [NUM_DEV-1:0]     stat_flat;
    logic [NUM_DEV-1:0]     en_flat;
    logic [NUM_LVL-1:0]     en_we;
    logic                   set_mode;
    logic [DEV_PER_LVL-1:0] mask;

    irq_sync #(.W(NUM_DEV)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (dev_req),
        .sync_out (stat_flat)
    );

    irq_regbus u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wr_data   (wr_data),
        .stat_flat (stat_flat),
        .en_flat   (en_flat),
        .en_we     (en_we),
        .set_mode  (set_mode),
        .mask      (mask),
        .rd_data   (rd_data)
    );

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        irq_level #(.NDEV(DEV_PER_LVL)) u_lvl (
            .clk      (clk),
            .rst_n    (rst_n),
            .stat     (stat_flat[g*DEV_PER_LVL +: DEV_PER_LVL]),
            .we       (en_we[g]),
            .set_mode (set_mode),
            .mask     (mask),
            .en_q     (en_flat[g*DEV_PER_LVL +: DEV_PER_LVL]),
            .irq_q    (irq_out[g])
        );
    end
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk
    import irq_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     addr,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [DATA_W-1:0]     wr_data,
    input logic [DATA_W-1:0]     rd_data,
    input logic [NUM_LVL-1:0]    irq_out,
    input logic [NUM_DEV-1:0]    en_flat
);
    logic any_hit;

    always_comb begin
        any_hit = 1'b0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (addr == stat_addr(i) || addr == en_addr(i)) any_hit = 1'b1;
        end
    end

    // R8
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:DEV_PER_LVL] == '0);

    // R9
    stray_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !any_hit) |=> (rd_data == '0));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_chk
        // R5
        set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == en_addr(g) && wr_data[MODE_BIT]) |=>
            ((en_flat[g*DEV_PER_LVL +: DEV_PER_LVL] & $past(wr_data[DEV_PER_LVL-1:0]))
                == $past(wr_data[DEV_PER_LVL-1:0])));

        // R6
        clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == en_addr(g) && !wr_data[MODE_BIT]) |=>
            ((en_flat[g*DEV_PER_LVL +: DEV_PER_LVL] & $past(wr_data[DEV_PER_LVL-1:0])) == '0));

        // R9
        en_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && addr == en_addr(g)) |=> $stable(en_flat[g*DEV_PER_LVL +: DEV_PER_LVL]));

        // R7
        masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en_flat[g*DEV_PER_LVL +: DEV_PER_LVL] == '0) |=> !irq_out[g]);
    end
endmodule

bind irq_level_ctrl irq_level_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq_out (irq_out),
    .en_flat (en_flat)
);

// File: tb/irq_level_ctrl_tb.sv
module irq_level_ctrl_tb;
    import irq_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic [NUM_DEV-1:0] dev_req = '0;
    logic [NUM_LVL-1:0] irq_out;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    irq_level_ctrl u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .dev_req (dev_req),
        .irq_out (irq_out)
    );

    // {level index, write data, expected enable readback}
    localparam logic [13:0] VEC [12] = '{
        {2'd1, 8'h81, 4'h1},
        {2'd1, 8'h86, 4'h7},
        {2'd1, 8'h02, 4'h5},
        {2'd1, 8'h02, 4'h5},
        {2'd1, 8'h84, 4'h5},
        {2'd1, 8'h8F, 4'hF},
        {2'd1, 8'h0F, 4'h0},
        {2'd0, 8'h83, 4'h3},
        {2'd2, 8'h88, 4'h8},
        {2'd3, 8'h85, 4'h5},
        {2'd0, 8'h01, 4'h2},
        {2'd3, 8'hF0, 4'h5}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    function automatic logic [ADDR_W-1:0] ier(input int lvl);
        return ADDR_W'(12'h104 + 12'h10 * lvl);
    endfunction

    function automatic logic [ADDR_W-1:0] isr(input int lvl);
        return ADDR_W'(12'h100 + 12'h10 * lvl);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 irq", irq_out, 0);
        check("R1 rd_data", rd_data, 0);
        rst_n = 1'b1;
        for (int l = 3; l <= 6; l++) begin
            bus_rd(ier(l), d);
            check("R1 enable", d, 0);
        end

        // R5 R6 R4 table walk
        for (int i = 0; i < 12; i++) begin
            bus_wr(ier(VEC[i][13:12] + 3), VEC[i][11:4]);
            bus_rd(ier(VEC[i][13:12] + 3), d);
            check(VEC[i][11] ? "R5 set" : "R6 clear", d, {4'h0, VEC[i][3:0]});
        end
        // enables now: L3=2 L4=0 L5=8 L6=5

        // R2 R3 R7 request mapping
        @(negedge clk);
        dev_req = 16'h28F2;
        repeat (2) @(negedge clk);
        check("R7 not before third edge", irq_out, 0);
        @(negedge clk);
        check("R7 R2 irq map", irq_out, 4'b0101);
        bus_rd(isr(4), d);
        check("R3 unmasked status L4", d, 8'h0F);
        bus_rd(isr(6), d);
        check("R3 status L6", d, 8'h02);
        bus_rd(isr(3), d);
        check("R3 R8 status L3", d, 8'h02);

        // R10 hold
        repeat (4) @(negedge clk);
        check("R10 hold", rd_data, 8'h02);

        // R7 enable-to-irq latency
        bus_wr(ier(6), 8'h82);
        check("R7 irq lags enable", irq_out[3], 1'b0);
        @(negedge clk);
        check("R7 irq after enable", irq_out[3], 1'b1);

        // R7 input falling latency
        dev_req[1] = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 still high", irq_out[0], 1'b1);
        @(negedge clk);
        check("R7 dropped", irq_out[0], 1'b0);

        // R9 stray accesses
        bus_rd(12'h138, d);
        check("R9 stray read", d, 0);
        bus_rd(12'h174, d);
        check("R9 level7 read", d, 0);
        bus_rd(12'h120, d);
        check("R9 level2 read", d, 0);
        bus_wr(12'h174, 8'h8F);
        bus_wr(12'h138, 8'h8F);
        bus_wr(isr(3), 8'h8F);
        bus_wr(isr(4), 8'h8F);
        bus_rd(ier(3), d);
        check("R9 L3 enable kept", d, 8'h02);
        bus_rd(ier(4), d);
        check("R9 L4 enable kept", d, 8'h00);
        check("R9 L4 irq quiet", irq_out[1], 1'b0);
        bus_rd(ier(6), d);
        check("R9 L6 enable kept", d, 8'h07);

        // R1 reset again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", irq_out, 0);
        bus_rd(ier(5), d);
        check("R1 enable after reset", d, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule